// File: doc/BRIEF.md
# Dual-Mode Serial Control Port

This block receives 16-bit command words from a host controller and turns each complete, valid word into a single-cycle write strobe for a small register file. The word carries a 7-bit register address in its upper bits and 9 bits of data in its lower bits, and is sent MSB first. The port only accepts writes. It never returns data.

Two serial protocols share the same clock pin and data pin. After reset the port speaks an addressed two-wire protocol. A transfer opens with a start condition and carries the device address with a direction bit, then the high and low command bytes, and closes with a stop condition. The port acknowledges each accepted byte by pulling the open-drain data line low for the ninth clock. A pulse on the latch pin (low, then high, then low) moves the port into a three-wire clock/data/latch protocol, and it remains there until the mode-clear input is pulsed. In three-wire mode, bits shift in on rising clock edges while the latch pin is low. The rising edge of the latch pin then commits the last 16 bits, provided the select pin is low.

The select pin also acts as the low bit of the two-wire device address. Every pin passes through a synchroniser to the system clock. Words whose address lies outside the four implemented registers are accepted on the bus but produce no strobe.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset the port is in two-wire mode (`mode_3w_o`=0), `sda_oe_o` is 0 and `wr_en_o` is 0.
- R2: In two-wire mode, this sequence produces exactly one strobe: a start (data falls while clock high), an address byte equal to {6'b001101, sel_i, 0} sent MSB first with bit 0 being R/W, a high command byte, a low command byte, then a stop (data rises while clock high). The strobe presents `wr_addr_o` = word[15:9] and `wr_data_o` = word[8:0], where word = {high byte, low byte}, and it appears after the stop.
- R3: For an accepted address byte and for both command bytes, `sda_oe_o` goes to 1 after the clock falls following the eighth bit. It stays 1 through the ninth clock high phase and returns to 0 on the next clock fall. It changes only while the clock is low.
- R4: If the address byte does not match (a different address, the wrong strap bit, or R/W=1), no byte of that transfer is acknowledged and no strobe is issued.
- R5: A word whose address is 4 or more is still acknowledged, but no strobe is issued. `wr_en_o` is never 1 with `wr_addr_o` ≥ 4.
- R6: In two-wire mode, a rise followed by a fall of `lat_i` sets `mode_3w_o` to 1 without issuing a strobe. The mode then stays 1 until `mode_clr_i` is pulsed.
- R7: In three-wire mode, data bits are sampled on rising `scl_i` edges while `lat_i` is low. A rising edge of `lat_i` while `sel_i` is 0 writes the last 16 sampled bits, with the same address/data split as R2.
- R8: In three-wire mode, a rising edge of `lat_i` while `sel_i` is 1 issues no strobe.
- R9: A one-cycle pulse of `mode_clr_i` returns the port to two-wire mode in the next cycle, and two-wire writes work again.
- R10: `wr_en_o` is never high for two consecutive cycles. Each complete word gives at most one strobe.
- R11: In three-wire mode, two-wire traffic is neither acknowledged nor written.
- R12: A start or stop that arrives before the low byte has been acknowledged discards the partial word. A new start begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_clr_i | input | 1 | Synchronous pulse that forces two-wire mode |
| scl_i | input | 1 | Serial clock pin (both modes) |
| sda_i | input | 1 | Resolved serial data line |
| lat_i | input | 1 | Latch pin for three-wire mode; its pulse selects three-wire mode |
| sel_i | input | 1 | Three-wire select (active low); low bit of the two-wire device address |
| sda_oe_o | output | 1 | Pull data line low (acknowledge) when 1 |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address for the write |
| wr_data_o | output | 9 | Register data for the write |
| mode_3w_o | output | 1 | 1 when the three-wire protocol is active |

## Verification
A wrong state in the two-wire sequencer shows at the pins within one serial bit. The acknowledge would then appear on the wrong clock, on a byte that should be refused, or not at all. A bad shift or byte register shows only later, as wrong address or data on the strobe after the stop. A stuck mode flag shows at once on `mode_3w_o`, and it also removes the acknowledges on the next two-wire transfer. The bench therefore samples the line in the middle of each ninth clock and compares every strobe's address and data. It also checks strobe counts after aborted, refused and out-of-range words.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int CMD_W  = 16;
  localparam int ADDR_W = 7;
  localparam int DATA_W = CMD_W - ADDR_W;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_ADDR,
    TW_HI,
    TW_LO,
    TW_ACK,
    TW_DONE
  } tw_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int               WIDTH   = 4,
  parameter int               EDGE_W  = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  d_i,
  output logic [WIDTH-1:0]  q_o,
  output logic [EDGE_W-1:0] rise_o,
  output logic [EDGE_W-1:0] fall_o
);
  // synchroniser chain per pin
  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    logic [STAGES-1:0] ch_q, ch_d;
    always_comb ch_d = {ch_q[STAGES-2:0], d_i[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= {STAGES{RST_VAL[g]}};
      else        ch_q <= ch_d;
    end
    assign q_o[g] = ch_q[STAGES-1];
  end

  // edge detect on the low EDGE_W pins
  for (genvar e = 0; e < EDGE_W; e++) begin : g_edge
    logic prv_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= RST_VAL[e];
      else        prv_q <= q_o[e];
    end
    assign rise_o[e] = q_o[e] & ~prv_q;
    assign fall_o[e] = ~q_o[e] & prv_q;
  end
endmodule

// File: rtl/mode_tracker.sv
module mode_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic lat_rise_i,
  input  logic lat_fall_i,
  output logic mode_3w_o
);
  logic seen_q, seen_d;
  logic m_q, m_d;

  always_comb begin
    seen_d = seen_q;
    m_d    = m_q;
    if (clr_i) begin
      seen_d = 1'b0;
      m_d    = 1'b0;
    end else if (!m_q) begin
      if (lat_rise_i) seen_d = 1'b1;
      if (lat_fall_i && seen_q) m_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      m_q    <= 1'b0;
    end else begin
      seen_q <= seen_d;
      m_q    <= m_d;
    end
  end

  assign mode_3w_o = m_q;
endmodule

// File: rtl/tw_engine.sv
module tw_engine import sctl_pkg::*; #(
  parameter logic [5:0] DEV_HI = 6'b001101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             scl_q_i,
  input  logic             sda_q_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_rise_i,
  input  logic             sda_fall_i,
  input  logic             addr_lsb_i,
  output logic             sda_oe_o,
  output logic             wr_o,
  output logic [CMD_W-1:0] word_o
);
  localparam int              CNT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tw_state_t         state_q, state_d, ret_q, ret_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, hi_q, hi_d, lo_q, lo_d;
  logic [1:0]        ph_q, ph_d;
  logic              oe_q, oe_d, wr_q, wr_d;
  logic [BYTE_W-1:0] byte_v;
  logic              start_c, stop_c;

  assign byte_v  = {sh_q[BYTE_W-2:0], sda_q_i};
  assign start_c = scl_q_i & sda_fall_i;
  assign stop_c  = scl_q_i & sda_rise_i;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    ph_d    = ph_q;
    oe_d    = oe_q;
    wr_d    = 1'b0;
    if (!en_i) begin
      state_d = TW_IDLE;
      oe_d    = 1'b0;
    end else if (start_c) begin
      state_d = TW_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_c) begin
      wr_d    = (state_q == TW_DONE);
      state_d = TW_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        TW_ADDR, TW_HI, TW_LO: begin
          if (scl_rise_i) begin
            sh_d  = byte_v;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              cnt_d = '0;
              ph_d  = 2'd0;
              if (state_q == TW_ADDR) begin
                if (byte_v[7:1] == {DEV_HI, addr_lsb_i} && !byte_v[0]) begin
                  state_d = TW_ACK;
                  ret_d   = TW_HI;
                end else begin
                  state_d = TW_IDLE;
                end
              end else if (state_q == TW_HI) begin
                hi_d    = byte_v;
                state_d = TW_ACK;
                ret_d   = TW_LO;
              end else begin
                lo_d    = byte_v;
                state_d = TW_ACK;
                ret_d   = TW_DONE;
              end
            end
          end
        end
        TW_ACK: begin
          case (ph_q)
            2'd0: if (scl_fall_i) begin oe_d = 1'b1; ph_d = 2'd1; end
            2'd1: if (scl_rise_i) ph_d = 2'd2;
            default: if (scl_fall_i) begin oe_d = 1'b0; state_d = ret_q; end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TW_IDLE;
      ret_q   <= TW_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      ph_q    <= 2'd0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      ph_q    <= ph_d;
      oe_q    <= oe_d;
      wr_q    <= wr_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign wr_o     = wr_q;
  assign word_o   = {hi_q, lo_q};
endmodule

// File: rtl/w3_engine.sv
module w3_engine import sctl_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             scl_rise_i,
  input  logic             sda_q_i,
  input  logic             lat_q_i,
  input  logic             lat_rise_i,
  input  logic             sel_q_i,
  output logic             wr_o,
  output logic [CMD_W-1:0] word_o
);
  logic [CMD_W-1:0] sh_q, sh_d;
  logic             wr_q, wr_d;

  always_comb begin
    sh_d = sh_q;
    if (en_i && scl_rise_i && !lat_q_i) sh_d = {sh_q[CMD_W-2:0], sda_q_i};
    wr_d = en_i && lat_rise_i && !sel_q_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      wr_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      wr_q <= wr_d;
    end
  end

  assign wr_o   = wr_q;
  assign word_o = sh_q;
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port import sctl_pkg::*; #(
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_HI      = 6'b001101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_clr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              lat_i,
  input  logic              sel_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mode_3w_o
);
  localparam int               PINS     = 4;
  localparam int               EDGES    = 3;
  localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(NUM_REGS);

  logic [PINS-1:0]  pins_q;
  logic [EDGES-1:0] rise, fall;
  logic             scl_s, sda_s, lat_s, sel_s;
  logic             mode_3w;
  logic             tw_wr, w3_wr;
  logic [CMD_W-1:0] tw_word, w3_word;
  cmd_t             cmd;
  logic             raw_wr;

  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  // pin order: {sel, lat, sda, scl}; idle levels 1,0,1,1
  pin_sync #(
    .WIDTH(PINS), .EDGE_W(EDGES), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sel_i, lat_i, sda_i, scl_i}),
    .q_o(pins_q), .rise_o(rise), .fall_o(fall)
  );

  assign scl_s = pins_q[0];
  assign sda_s = pins_q[1];
  assign lat_s = pins_q[2];
  assign sel_s = pins_q[3];

  mode_tracker u_mode (
    .clk(clk), .rst_n(rst_n), .clr_i(mode_clr_i),
    .lat_rise_i(rise[2]), .lat_fall_i(fall[2]), .mode_3w_o(mode_3w)
  );

  tw_engine #(.DEV_HI(DEV_HI)) u_tw (
    .clk(clk), .rst_n(rst_n), .en_i(!mode_3w),
    .scl_q_i(scl_s), .sda_q_i(sda_s),
    .scl_rise_i(rise[0]), .scl_fall_i(fall[0]),
    .sda_rise_i(rise[1]), .sda_fall_i(fall[1]),
    .addr_lsb_i(sel_s),
    .sda_oe_o(sda_oe_o), .wr_o(tw_wr), .word_o(tw_word)
  );

  w3_engine u_w3 (
    .clk(clk), .rst_n(rst_n), .en_i(mode_3w),
    .scl_rise_i(rise[0]), .sda_q_i(sda_s),
    .lat_q_i(lat_s), .lat_rise_i(rise[2]), .sel_q_i(sel_s),
    .wr_o(w3_wr), .word_o(w3_word)
  );

  assign cmd    = mode_3w ? cmd_t'(w3_word) : cmd_t'(tw_word);
  assign raw_wr = tw_wr | w3_wr;

  always_comb begin
    wr_d   = raw_wr && (cmd.addr < ADDR_LIM);
    addr_d = raw_wr ? cmd.addr : addr_q;
    data_d = raw_wr ? cmd.data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
  assign mode_3w_o = mode_3w;
endmodule

// File: rtl/serial_ctrl_port_chk.sv
module serial_ctrl_port_chk #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_clr_i,
  input logic              scl_s,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              sda_oe_o,
  input logic              mode_3w_o
);
  localparam logic [ADDR_W-1:0] LIM = ADDR_W'(NUM_REGS);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o) else $error("strobe wider than one cycle");

  p_addr_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_addr_o < LIM)) else $error("strobe to unknown address");

  p_no_ack_3w_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_3w_o && $past(mode_3w_o)) |-> !sda_oe_o) else $error("ack in three-wire mode");

  p_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_3w_o && !mode_clr_i) |=> mode_3w_o) else $error("mode left three-wire");

  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr_i |=> !mode_3w_o) else $error("mode clear ignored");

  p_ack_drive_low_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_s) else $error("ack driven while clock high");

  p_ack_release_low_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_s) else $error("ack released while clock high");
endmodule

bind serial_ctrl_port serial_ctrl_port_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_clr_i(mode_clr_i), .scl_s(scl_s),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .sda_oe_o(sda_oe_o), .mode_3w_o(mode_3w_o)
);

// File: tb/serial_ctrl_port_tb.sv
module serial_ctrl_port_tb;
  localparam int H  = 8;
  localparam int NV = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mode_clr, scl_h, sda_h, lat_h, sel_h;
  logic sda_line;
  logic sda_oe, wr_en, mode_3w;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  assign sda_line = sda_oe ? 1'b0 : sda_h;

  serial_ctrl_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_clr_i(mode_clr),
    .scl_i(scl_h), .sda_i(sda_line), .lat_i(lat_h), .sel_i(sel_h),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .mode_3w_o(mode_3w)
  );

  int checks = 0;
  int errors = 0;
  int strobe_cnt = 0;
  logic [6:0] last_addr = '0;
  logic [8:0] last_data = '0;
  logic prev_wr = 1'b0;
  logic wide_seen = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) begin
    if (wr_en === 1'b1) begin
      strobe_cnt <= strobe_cnt + 1;
      last_addr  <= wr_addr;
      last_data  <= wr_data;
      if (prev_wr) wide_seen <= 1'b1;
    end
    prev_wr <= (wr_en === 1'b1);
  end

  // {sel, addr byte, word, expect ack, expect write}
  localparam logic [26:0] VECS [NV] = '{
    {1'b0, 8'h34, 16'h00AB, 1'b1, 1'b1},
    {1'b1, 8'h36, 16'h07C5, 1'b1, 1'b1},
    {1'b1, 8'h34, 16'h0211, 1'b0, 1'b0},
    {1'b0, 8'h35, 16'h0211, 1'b0, 1'b0},
    {1'b0, 8'h34, 16'h1255, 1'b1, 1'b0},
    {1'b0, 8'h34, 16'h05FF, 1'b1, 1'b1},
    {1'b0, 8'h7A, 16'h0001, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tw_start();
    sda_h = 1'b1; clks(H);
    scl_h = 1'b1; clks(H);
    sda_h = 1'b0; clks(H);
    scl_h = 1'b0; clks(H);
  endtask

  task automatic tw_stop();
    sda_h = 1'b0; clks(H);
    scl_h = 1'b1; clks(H);
    sda_h = 1'b1; clks(H);
  endtask

  task automatic tw_bit(input logic b);
    sda_h = b;    clks(H);
    scl_h = 1'b1; clks(H);
    scl_h = 1'b0; clks(H);
  endtask

  task automatic tw_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) tw_bit(b[i]);
    sda_h = 1'b1; clks(H);
    scl_h = 1'b1; clks(H/2);
    ack = ~sda_line;
    clks(H/2);
    scl_h = 1'b0; clks(H);
  endtask

  task automatic w3_word(input logic [15:0] w, input logic s);
    sel_h = s;
    scl_h = 1'b0; clks(H);
    for (int i = 15; i >= 0; i--) begin
      sda_h = w[i]; clks(H);
      scl_h = 1'b1; clks(H);
      scl_h = 1'b0; clks(H);
    end
    lat_h = 1'b1; clks(H);
    lat_h = 1'b0; clks(H);
  endtask

  task automatic tw_word(input logic [7:0] ab, input logic [15:0] w,
                         output logic a0, output logic a1, output logic a2);
    tw_start();
    tw_byte(ab, a0);
    tw_byte(w[15:8], a1);
    tw_byte(w[7:0], a2);
    tw_stop();
    clks(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    int base;
    rst_n = 1'b0; mode_clr = 1'b0;
    scl_h = 1'b1; sda_h = 1'b1; lat_h = 1'b0; sel_h = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(5);

    // R1 reset state
    chk("R1 mode", 32'(mode_3w), 32'd0);
    chk("R1 oe", 32'(sda_oe), 32'd0);
    chk("R1 strobe", 32'(wr_en), 32'd0);

    // table walk: R2, R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      logic [26:0] e;
      e = VECS[v];
      sel_h = e[26];
      clks(H);
      base = strobe_cnt;
      tw_word(e[25:18], e[17:2], a0, a1, a2);
      chk("R3/R4 addr ack", 32'(a0), 32'(e[1]));
      chk("R3/R4 high ack", 32'(a1), 32'(e[1]));
      chk("R3/R4 low ack", 32'(a2), 32'(e[1]));
      chk("R2/R5 strobe count", 32'(strobe_cnt - base), 32'(e[0]));
      if (e[0]) begin
        chk("R2 addr", 32'(last_addr), 32'(e[17:11]));
        chk("R2 data", 32'(last_data), 32'(e[10:2]));
      end
    end

    // R12 repeated start after high byte
    sel_h = 1'b0;
    base = strobe_cnt;
    tw_start();
    tw_byte(8'h34, a0);
    tw_byte(8'h02, a1);
    tw_word(8'h34, 16'h0333, a0, a1, a2);
    chk("R12 restart count", 32'(strobe_cnt - base), 32'd1);
    chk("R12 restart addr", 32'(last_addr), 32'd1);
    chk("R12 restart data", 32'(last_data), 32'h133);

    // R12 stop before low byte
    base = strobe_cnt;
    tw_start();
    tw_byte(8'h34, a0);
    tw_byte(8'h04, a1);
    tw_stop();
    clks(10);
    chk("R12 abort count", 32'(strobe_cnt - base), 32'd0);

    // R6 mode switch
    base = strobe_cnt;
    lat_h = 1'b1; clks(H);
    lat_h = 1'b0; clks(H);
    chk("R6 mode set", 32'(mode_3w), 32'd1);
    chk("R6 no strobe", 32'(strobe_cnt - base), 32'd0);

    // R11 two-wire ignored in three-wire mode
    scl_h = 1'b1; sda_h = 1'b1; sel_h = 1'b0; clks(H);
    base = strobe_cnt;
    tw_word(8'h34, 16'h0222, a0, a1, a2);
    chk("R11 no ack", 32'({a0, a1, a2}), 32'd0);
    chk("R11 no strobe", 32'(strobe_cnt - base), 32'd0);

    // R7 three-wire write
    base = strobe_cnt;
    w3_word(16'h0323, 1'b0);
    clks(10);
    chk("R7 count", 32'(strobe_cnt - base), 32'd1);
    chk("R7 addr", 32'(last_addr), 32'd1);
    chk("R7 data", 32'(last_data), 32'h123);

    // R5 three-wire unknown address
    base = strobe_cnt;
    w3_word(16'h0A0F, 1'b0);
    clks(10);
    chk("R5 3w discard", 32'(strobe_cnt - base), 32'd0);

    // R8 select high
    base = strobe_cnt;
    w3_word(16'h07AA, 1'b1);
    clks(10);
    chk("R8 deselected", 32'(strobe_cnt - base), 32'd0);

    // R7 all-zero word to address 0
    base = strobe_cnt;
    w3_word(16'h0000, 1'b0);
    clks(10);
    chk("R7 zero count", 32'(strobe_cnt - base), 32'd1);
    chk("R7 zero addr", 32'(last_addr), 32'd0);
    chk("R7 zero data", 32'(last_data), 32'd0);
    chk("R6 sticky", 32'(mode_3w), 32'd1);

    // R9 mode clear
    scl_h = 1'b1; sda_h = 1'b1; clks(H);
    mode_clr = 1'b1; clks(1);
    mode_clr = 1'b0; clks(2);
    chk("R9 mode cleared", 32'(mode_3w), 32'd0);
    base = strobe_cnt;
    tw_word(8'h34, 16'h0456, a0, a1, a2);
    chk("R9 ack", 32'({a0, a1, a2}), 32'd7);
    chk("R9 count", 32'(strobe_cnt - base), 32'd1);
    chk("R9 addr", 32'(last_addr), 32'd2);
    chk("R9 data", 32'(last_data), 32'h056);

    // R10 strobe width
    chk("R10 single-cycle strobes", 32'(wide_seen), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule